// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block runs one vector operation over its elements and issues one register request per element. The operation has a destination operand and two source operands. Each operand has a base register number, a vector/scalar tag and an external remapper. A start pulse loads the base registers, the vector length, the predicate mask and the three tags. The block then visits elements 0 up to VL-1, one per clock. For each visited element it checks the matching predicate bit. When that bit is set, it presents the three register numbers on an issue strobe.

Each operand has its own element index, which the block drives out on an index port. A remapper outside the block turns that index into a register offset and feeds it back on the same cycle. The register number issued for the operand is its base plus that offset. A vector operand's index follows the element counter. A scalar operand's index stays at zero. A scalar destination ends the loop after the first element it visits.

The element counter itself is the element-state register. It is visible at all times and keeps its value after the loop stops. If an element would address a register past the end of the register file, the block raises an illegal-instruction flag and halts at that element. A later resume pulse restarts the loop at the saved element instead of at element 0.

Top module: `vector_loop_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `issue_o`, `done_o` and `illegal_o` are low, and `elem_state_o` is 0.
- R2: A start pulse while idle begins the loop at element 0 on the next cycle. The loop visits one element per cycle in increasing order, and `elem_state_o` shows the element being visited.
- R3: `issue_o` is high in an element's cycle only if bit i of the predicate mask is set. Bit 0 belongs to element 0. Elements whose bit is clear are visited but not issued.
- R4: Each issued register number equals that operand's base plus the offset on its remap input, modulo the register file size. The three operands are computed independently.
- R5: A vector-tagged operand's index output equals the current element. A scalar-tagged operand's index output stays 0 for the whole loop.
- R6: When the destination is tagged scalar, the loop ends after the first element it visits.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last visited element. `busy_o` is high from the first loop cycle through that cycle, and low afterwards.
- R8: A start with VL equal to 0 gives `done_o` in the next cycle, with no issue.
- R9: On a predicated element, if any operand's base plus offset is at or above the register file size, `illegal_o` is high for that cycle and nothing is issued. The loop then stops without `done_o`, and `elem_state_o` keeps that element. Unpredicated elements are not range-checked.
- R10: A resume pulse while idle loads fresh operands but starts at the element held in `elem_state_o`. Vector operands start their index at that element. If the saved element is at or beyond VL, `done_o` follows at once with no issue.
- R11: Start and resume pulses that arrive while the block is busy are ignored. The running loop's trace is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a loop at element 0 (taken only while idle) |
| resume_i | input | 1 | Begin a loop at the saved element (taken only while idle; start wins) |
| base_rd_i | input | RN_W | Destination base register |
| base_rs1_i | input | RN_W | First source base register |
| base_rs2_i | input | RN_W | Second source base register |
| vl_i | input | VL_W | Vector length |
| pred_i | input | VL_MAX | Predicate mask, bit i for element i |
| vec_rd_i | input | 1 | Destination is a vector |
| vec_rs1_i | input | 1 | First source is a vector |
| vec_rs2_i | input | 1 | Second source is a vector |
| rd_off_i | input | IX_W | Remapped offset for the destination index |
| rs1_off_i | input | IX_W | Remapped offset for the first source index |
| rs2_off_i | input | IX_W | Remapped offset for the second source index |
| rd_idx_o | output | IX_W | Destination element index, sent to its remapper |
| rs1_idx_o | output | IX_W | First source element index |
| rs2_idx_o | output | IX_W | Second source element index |
| elem_state_o | output | IX_W | Saved or current element index |
| busy_o | output | 1 | Loop in progress |
| issue_o | output | 1 | Register request valid this cycle |
| iss_rd_o | output | RN_W | Issued destination register |
| iss_rs1_o | output | RN_W | Issued first source register |
| iss_rs2_o | output | RN_W | Issued second source register |
| done_o | output | 1 | Loop finished (one cycle) |
| illegal_o | output | 1 | Register number out of range; loop halted |

## Verification
A corrupted element counter or operand index shows up on the same cycle. It gives a wrong `elem_state_o`, a wrong issued register, or an issue on an element whose predicate bit is clear. A lost scalar tag or a wrong last-element test shows up one cycle later, as a `done_o` that is early, late or missing. A saved index that is wrong only becomes visible on the next resume, in the first element that resume issues. For that reason the bench drives resumes after both an illegal halt and a normal finish, and compares every cycle against a trace built from the requirements.

// File: rtl/vls_pkg.sv
// Package: shared types for the vector loop sequencer.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package vls_pkg;

    // Loop controller states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } sq_state_e;

    // Operand slots, in the order used by the top-level arrays
    localparam int NUM_OPS = 3;
    localparam int OP_RD   = 0;
    localparam int OP_RS1  = 1;
    localparam int OP_RS2  = 2;

endpackage

// File: rtl/vls_operand.sv
// Module: vls_operand
// One operand lane. It holds the operand's base register, its vector tag and
// its element index. From the offset that an external remapper returns for the
// current index, it forms the register number and flags a number at or above
// NREG.
// Assumes: the offset input is a combinational function of idx_o.
module vls_operand #(
    parameter int IX_W = 4,
    parameter int RN_W = 5,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [IX_W-1:0] load_idx_i,
    input  logic            is_vec_i,
    input  logic [RN_W-1:0] base_i,
    input  logic            step_i,
    input  logic [IX_W-1:0] off_i,
    output logic [IX_W-1:0] idx_o,
    output logic [RN_W-1:0] regnum_o,
    output logic            over_o
);
    localparam int SUM_W = ((RN_W > IX_W) ? RN_W : IX_W) + 1;

    logic            vec_q;
    logic [RN_W-1:0] base_q;
    logic [IX_W-1:0] idx_q;
    logic [SUM_W-1:0] sum;

    // Capture the operand at launch and advance a vector index per element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            vec_q  <= is_vec_i;
            base_q <= base_i;
            idx_q  <= is_vec_i ? load_idx_i : '0;
        end else if (step_i && vec_q) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Register number and range check for the current remapped offset
    always_comb begin
        sum      = SUM_W'(base_q) + SUM_W'(off_i);
        over_o   = (sum >= SUM_W'(NREG));
        regnum_o = sum[RN_W-1:0];
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/vls_seq.sv
// Module: vls_seq
// Element loop controller. It owns the element counter, which doubles as the
// re-entry state. It walks the elements in order, gates issue with the
// predicate, ends early for a scalar destination, halts on a range fault and
// pulses done.
// Assumes: VL_MAX is a power of two, and any_over_i is valid in the same cycle.
module vls_seq
    import vls_pkg::*;
#(
    parameter int VL_MAX = 16,
    parameter int IX_W   = 4,
    parameter int VL_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              resume_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [VL_MAX-1:0] pred_i,
    input  logic              vec_rd_i,
    input  logic              any_over_i,
    output logic              load_o,
    output logic [IX_W-1:0]   load_idx_o,
    output logic              step_o,
    output logic [IX_W-1:0]   elem_o,
    output logic              busy_o,
    output logic              issue_o,
    output logic              done_o,
    output logic              illegal_o
);
    sq_state_e         state_q;
    sq_state_e         state_d;
    logic [IX_W-1:0]   ctr_q;
    logic [IX_W-1:0]   ctr_d;
    logic [VL_W-1:0]   vl_q;
    logic [VL_MAX-1:0] pred_q;
    logic              vrd_q;
    logic              active;
    logic              fault;
    logic              last;

    // Launch and per-element decisions
    always_comb begin
        state_d    = state_q;
        ctr_d      = ctr_q;
        load_o     = 1'b0;
        load_idx_o = start_i ? '0 : ctr_q;
        step_o     = 1'b0;
        active     = 1'b0;
        fault      = 1'b0;
        last       = 1'b0;
        issue_o    = 1'b0;
        illegal_o  = 1'b0;
        done_o     = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                if (start_i || resume_i) begin
                    load_o = 1'b1;
                    ctr_d  = load_idx_o;
                    if (VL_W'(load_idx_o) >= vl_i) state_d = SQ_FIN;
                    else                           state_d = SQ_RUN;
                end
            end
            SQ_RUN: begin
                active    = pred_q[ctr_q];
                fault     = active && any_over_i;
                issue_o   = active && !any_over_i;
                illegal_o = fault;
                last      = ((VL_W'(ctr_q) + VL_W'(1)) == vl_q) || !vrd_q;
                if (fault) begin
                    state_d = SQ_IDLE;
                end else if (last) begin
                    state_d = SQ_FIN;
                end else begin
                    step_o = 1'b1;
                    ctr_d  = ctr_q + 1'b1;
                end
            end
            SQ_FIN: begin
                done_o  = 1'b1;
                state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State, element counter and launch-time copies of the loop controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ctr_q   <= '0;
            vl_q    <= '0;
            pred_q  <= '0;
            vrd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ctr_q   <= ctr_d;
            if (load_o) begin
                vl_q   <= vl_i;
                pred_q <= pred_i;
                vrd_q  <= vec_rd_i;
            end
        end
    end

    assign elem_o = ctr_q;
    assign busy_o = (state_q != SQ_IDLE);

endmodule

// File: rtl/vector_loop_seq.sv
// Module: vector_loop_seq (top)
// Sequences one predicated vector operation over a destination and two
// sources. The operand lanes come from a generate loop. Each lane exports its
// element index to an external remapper and receives the offset back.
// Assumes: NREG and VL_MAX are powers of two, and the remappers are
// combinational.
module vector_loop_seq
    import vls_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int VL_MAX = 16,
    localparam int RN_W  = $clog2(NREG),
    localparam int IX_W  = $clog2(VL_MAX),
    localparam int VL_W  = $clog2(VL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              resume_i,
    input  logic [RN_W-1:0]   base_rd_i,
    input  logic [RN_W-1:0]   base_rs1_i,
    input  logic [RN_W-1:0]   base_rs2_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [VL_MAX-1:0] pred_i,
    input  logic              vec_rd_i,
    input  logic              vec_rs1_i,
    input  logic              vec_rs2_i,
    input  logic [IX_W-1:0]   rd_off_i,
    input  logic [IX_W-1:0]   rs1_off_i,
    input  logic [IX_W-1:0]   rs2_off_i,
    output logic [IX_W-1:0]   rd_idx_o,
    output logic [IX_W-1:0]   rs1_idx_o,
    output logic [IX_W-1:0]   rs2_idx_o,
    output logic [IX_W-1:0]   elem_state_o,
    output logic              busy_o,
    output logic              issue_o,
    output logic [RN_W-1:0]   iss_rd_o,
    output logic [RN_W-1:0]   iss_rs1_o,
    output logic [RN_W-1:0]   iss_rs2_o,
    output logic              done_o,
    output logic              illegal_o
);
    logic [RN_W-1:0] base_a [NUM_OPS];
    logic            vec_a  [NUM_OPS];
    logic [IX_W-1:0] off_a  [NUM_OPS];
    logic [IX_W-1:0] idx_a  [NUM_OPS];
    logic [RN_W-1:0] reg_a  [NUM_OPS];
    logic [NUM_OPS-1:0] over_v;
    logic            load;
    logic [IX_W-1:0] load_idx;
    logic            step;

    // Gather the per-operand ports into lane arrays
    always_comb begin
        base_a[OP_RD]  = base_rd_i;
        base_a[OP_RS1] = base_rs1_i;
        base_a[OP_RS2] = base_rs2_i;
        vec_a[OP_RD]   = vec_rd_i;
        vec_a[OP_RS1]  = vec_rs1_i;
        vec_a[OP_RS2]  = vec_rs2_i;
        off_a[OP_RD]   = rd_off_i;
        off_a[OP_RS1]  = rs1_off_i;
        off_a[OP_RS2]  = rs2_off_i;
    end

    vls_seq #(
        .VL_MAX (VL_MAX),
        .IX_W   (IX_W),
        .VL_W   (VL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .resume_i   (resume_i),
        .vl_i       (vl_i),
        .pred_i     (pred_i),
        .vec_rd_i   (vec_rd_i),
        .any_over_i (|over_v),
        .load_o     (load),
        .load_idx_o (load_idx),
        .step_o     (step),
        .elem_o     (elem_state_o),
        .busy_o     (busy_o),
        .issue_o    (issue_o),
        .done_o     (done_o),
        .illegal_o  (illegal_o)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        vls_operand #(
            .IX_W (IX_W),
            .RN_W (RN_W),
            .NREG (NREG)
        ) u_op (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load),
            .load_idx_i (load_idx),
            .is_vec_i   (vec_a[g]),
            .base_i     (base_a[g]),
            .step_i     (step),
            .off_i      (off_a[g]),
            .idx_o      (idx_a[g]),
            .regnum_o   (reg_a[g]),
            .over_o     (over_v[g])
        );
    end

    assign rd_idx_o  = idx_a[OP_RD];
    assign rs1_idx_o = idx_a[OP_RS1];
    assign rs2_idx_o = idx_a[OP_RS2];
    assign iss_rd_o  = reg_a[OP_RD];
    assign iss_rs1_o = reg_a[OP_RS1];
    assign iss_rs2_o = reg_a[OP_RS2];

endmodule

// File: rtl/vls_checker.sv
// Module: vls_checker
// Temporal properties on the sequencer's ports, bound to every instance of
// the top module.
// Assumes: synchronous active-low reset held for at least one edge.
module vls_checker #(
    parameter int IX_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            resume_i,
    input logic            busy_o,
    input logic            issue_o,
    input logic            done_o,
    input logic            illegal_o,
    input logic [IX_W-1:0] elem_state_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R7
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);  // R7
    AST_ISSUE_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> (busy_o && !done_o));  // R3
    AST_FAULT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !issue_o);  // R9
    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> (!busy_o && !done_o));  // R9
    AST_ELEM_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && $past(busy_o) && !$past(done_o))
        |-> (elem_state_o == IX_W'($past(elem_state_o) + 1'b1)));  // R2
    AST_IDLE_KEEPS_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o && !start_i && !resume_i))
        |-> $stable(elem_state_o));  // R10
endmodule

bind vector_loop_seq vls_checker #(.IX_W(IX_W)) u_vls_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .resume_i     (resume_i),
    .busy_o       (busy_o),
    .issue_o      (issue_o),
    .done_o       (done_o),
    .illegal_o    (illegal_o),
    .elem_state_o (elem_state_o)
);

// File: tb/vector_loop_seq_tb.sv
`timescale 1ns/1ps
module vector_loop_seq_tb;
    localparam int NREG = 32;
    localparam int VLM  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, resume_i = 1'b0;
    logic [4:0] base_rd_i = '0, base_rs1_i = '0, base_rs2_i = '0;
    logic [4:0] vl_i = '0;
    logic [15:0] pred_i = '0;
    logic       vec_rd_i = 1'b0, vec_rs1_i = 1'b0, vec_rs2_i = 1'b0;
    logic [3:0] rd_off_i, rs1_off_i, rs2_off_i;
    logic [3:0] rd_idx_o, rs1_idx_o, rs2_idx_o, elem_state_o;
    logic       busy_o, issue_o, done_o, illegal_o;
    logic [4:0] iss_rd_o, iss_rs1_o, iss_rs2_o;

    int errors = 0;
    int checks = 0;
    int saved  = 0;
    int m_rd = 0, m_rs1 = 0, m_rs2 = 0;

    always #4 clk = ~clk;

    // External remappers: 0 identity, 1 reversal, 2 stride-5 permutation
    function automatic int remap(int m, int x);
        if (m == 1) return 15 - x;
        if (m == 2) return (x * 5) % 16;
        return x;
    endfunction

    assign rd_off_i  = 4'(remap(m_rd,  int'(rd_idx_o)));
    assign rs1_off_i = 4'(remap(m_rs1, int'(rs1_idx_o)));
    assign rs2_off_i = 4'(remap(m_rs2, int'(rs2_idx_o)));

    vector_loop_seq #(.NREG(NREG), .VL_MAX(VLM)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
        .base_rd_i(base_rd_i), .base_rs1_i(base_rs1_i), .base_rs2_i(base_rs2_i),
        .vl_i(vl_i), .pred_i(pred_i),
        .vec_rd_i(vec_rd_i), .vec_rs1_i(vec_rs1_i), .vec_rs2_i(vec_rs2_i),
        .rd_off_i(rd_off_i), .rs1_off_i(rs1_off_i), .rs2_off_i(rs2_off_i),
        .rd_idx_o(rd_idx_o), .rs1_idx_o(rs1_idx_o), .rs2_idx_o(rs2_idx_o),
        .elem_state_o(elem_state_o), .busy_o(busy_o), .issue_o(issue_o),
        .iss_rd_o(iss_rd_o), .iss_rs1_o(iss_rs1_o), .iss_rs2_o(iss_rs2_o),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    // Expected per-cycle trace
    int q_iss[$], q_rd[$], q_r1[$], q_r2[$], q_ill[$], q_done[$], q_elem[$];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic push(int iss, int rd, int r1, int r2, int ill, int dn, int el);
        q_iss.push_back(iss); q_rd.push_back(rd); q_r1.push_back(r1); q_r2.push_back(r2);
        q_ill.push_back(ill); q_done.push_back(dn); q_elem.push_back(el);
    endtask

    // Build the trace from the requirements, launch, and compare every cycle
    task automatic run_op(bit use_resume, int brd, int b1, int b2, int vl,
                          logic [15:0] pred, bit vrd, bit v1, bit v2,
                          int mr, int m1, int m2, bit poke);
        int s;
        s = use_resume ? saved : 0;
        q_iss.delete(); q_rd.delete(); q_r1.delete(); q_r2.delete();
        q_ill.delete(); q_done.delete(); q_elem.delete();
        if (s >= vl) begin
            push(0, 0, 0, 0, 0, 1, s); saved = s;
        end else begin
            for (int i = s; i < vl; i++) begin
                int srd, s1, s2;
                srd = brd + remap(mr, vrd ? i : 0);
                s1  = b1  + remap(m1, v1  ? i : 0);
                s2  = b2  + remap(m2, v2  ? i : 0);
                if (pred[i] && (srd >= NREG || s1 >= NREG || s2 >= NREG)) begin
                    push(0, 0, 0, 0, 1, 0, i); saved = i;
                    break;
                end
                push(pred[i] ? 1 : 0, srd % NREG, s1 % NREG, s2 % NREG, 0, 0, i);
                if (i == vl - 1 || !vrd) begin
                    push(0, 0, 0, 0, 0, 1, i); saved = i;
                    break;
                end
            end
        end
        @(negedge clk);
        base_rd_i = 5'(brd); base_rs1_i = 5'(b1); base_rs2_i = 5'(b2);
        vl_i = 5'(vl); pred_i = pred;
        vec_rd_i = vrd; vec_rs1_i = v1; vec_rs2_i = v2;
        m_rd = mr; m_rs1 = m1; m_rs2 = m2;
        start_i = !use_resume; resume_i = use_resume;
        @(negedge clk);
        start_i = 1'b0; resume_i = 1'b0;
        for (int k = 0; k < q_iss.size(); k++) begin
            chk(busy_o == 1'b1, "R7", "busy", int'(busy_o), 1);
            chk(int'(elem_state_o) == q_elem[k], "R2", "elem", int'(elem_state_o), q_elem[k]);
            chk(int'(issue_o) == q_iss[k], "R3", "issue", int'(issue_o), q_iss[k]);
            if (q_iss[k] == 1) begin
                chk(int'(iss_rd_o) == q_rd[k], "R4", "rd", int'(iss_rd_o), q_rd[k]);
                chk(int'(iss_rs1_o) == q_r1[k], "R4", "rs1", int'(iss_rs1_o), q_r1[k]);
                chk(int'(iss_rs2_o) == q_r2[k], "R4", "rs2", int'(iss_rs2_o), q_r2[k]);
            end
            chk(int'(done_o) == q_done[k], "R7", "done", int'(done_o), q_done[k]);
            chk(int'(illegal_o) == q_ill[k], "R9", "illegal", int'(illegal_o), q_ill[k]);
            // R11: a start/resume pulse during the loop must not disturb it
            if (poke && k == 1) begin start_i = 1'b1; resume_i = 1'b1; vl_i = '0; end
            if (poke && k == 2) begin start_i = 1'b0; resume_i = 1'b0; end
            @(negedge clk);
        end
        chk(busy_o == 1'b0 && done_o == 1'b0 && issue_o == 1'b0 && illegal_o == 1'b0,
            "R7", "idle after loop", int'({busy_o, done_o, issue_o, illegal_o}), 0);
        chk(int'(elem_state_o) == saved, "R10", "saved elem", int'(elem_state_o), saved);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy_o == 0 && issue_o == 0 && done_o == 0 && illegal_o == 0, "R1",
            "idle flags", int'({busy_o, issue_o, done_o, illegal_o}), 0);
        chk(elem_state_o == 4'd0, "R1", "elem", int'(elem_state_o), 0);
        // R2 R4 R5: full vector, identity remap
        run_op(0, 1, 2, 3, 8, 16'hFFFF, 1, 1, 1, 0, 0, 0, 0);
        // R3 R4: sparse predicate, different remap per operand
        run_op(0, 4, 0, 10, 16, 16'hA5A5, 1, 1, 1, 0, 1, 2, 0);
        // R5: scalar first source stays at index 0
        run_op(0, 0, 7, 16, 6, 16'h003F, 1, 0, 1, 2, 1, 0, 0);
        // R6: scalar destination ends after one element
        run_op(0, 5, 6, 7, 9, 16'hFFFF, 0, 1, 1, 1, 0, 0, 0);
        // R6: scalar destination with its element predicated off
        run_op(0, 5, 6, 7, 9, 16'hFFFE, 0, 1, 1, 0, 0, 0, 0);
        // R8: VL of zero
        run_op(0, 0, 0, 0, 0, 16'hFFFF, 1, 1, 1, 0, 0, 0, 0);
        // R9: overflow at element 8 masked, fault at element 10
        run_op(0, 24, 0, 0, 12, 16'hFCFF, 1, 1, 1, 0, 0, 0, 0);
        // R10: resume from the faulting element with a legal base
        run_op(1, 0, 1, 2, 12, 16'hFFFF, 1, 1, 1, 0, 0, 0, 0);
        // R10: resume after a finished loop, scalar second source
        run_op(1, 2, 3, 4, 16, 16'hF0F0, 1, 1, 0, 1, 2, 0, 0);
        // R10: resume where the saved element is beyond VL
        run_op(1, 0, 0, 0, 4, 16'hFFFF, 1, 1, 1, 0, 0, 0, 0);
        // R11: start/resume pulsed mid-loop are ignored
        run_op(0, 3, 3, 3, 10, 16'h3FF, 1, 1, 1, 2, 0, 1, 1);
        // R9: fault on the first source via reversal
        run_op(0, 0, 20, 0, 6, 16'h0001, 1, 1, 1, 0, 1, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule